// File: doc/BRIEF.md
# Oscillator Start-Up Delay Sequencer

This block keeps the core clock switched off after a reset or a wake-up until the low-power oscillator has had time to settle. It runs on the free-running low-power oscillator clock (nominally 128 kHz) and counts its cycles. When the count is complete, it raises a ready flag and the clock enable, and holds them high until the next reset or sleep request.

The hold-off has two forms. Wake from a sleep state always waits a short, fixed number of cycles. Reset waits a longer fixed count plus a millisecond-scale extension. A 2-bit select code picks that extension: none, 4 ms (512 cycles) or 64 ms (8192 cycles). Code 3 is not a valid choice. When it is given, the block raises an error flag and falls back to the longest extension.

The select code is captured once, when each delay starts. Later changes to it have no effect until the next delay.

Top module: `su_delay_seq`

## Requirements
- R1: While `rst_n` is low, `ready` and `clk_en` are low, and `dly_sel` is captured on every clock edge.
- R2: After reset release with `dly_sel` = 2'b00, `ready` rises on the 14th rising edge counted from the first edge that sees `rst_n` high.
- R3: After reset release with `dly_sel` = 2'b01, `ready` rises on edge 14 + 512 = 526.
- R4: After reset release with `dly_sel` = 2'b10, `ready` rises on edge 14 + 8192 = 8206, and the cycle counter never passes its terminal value.
- R5: `dly_sel` = 2'b11 sets `sel_err` high and gives the 8206-edge reset delay. A valid code leaves `sel_err` low. `sel_err` follows the code captured at the start of the current delay.
- R6: While `ready` is high, `sleep_req` high drops `ready` and `clk_en` on the next edge. In sleep, a `wake_req` edge starts a wake delay, and `ready` rises 6 edges after the capturing edge. This holds for every select code.
- R7: `clk_en` equals `ready`. Once high, both stay high until reset or a sleep request.
- R8: Changes to `dly_sel` during a delay do not change its length or `sel_err`.
- R9: `wake_req` and `sleep_req` during a delay, and `wake_req` while ready, have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_osc | input | 1 | Low-power oscillator clock |
| rst_n | input | 1 | Synchronous active-low reset request |
| sleep_req | input | 1 | Enter sleep (honoured only when ready) |
| wake_req | input | 1 | Leave sleep (honoured only in sleep) |
| dly_sel | input | 2 | Reset extension select: 00 none, 01 512 cycles, 10 8192 cycles, 11 reserved |
| ready | output | 1 | Start-up delay complete |
| clk_en | output | 1 | Core clock enable |
| sel_err | output | 1 | Captured select code was reserved |

## Verification
The assertions assume that `rst_n`, `sleep_req` and `wake_req` are already synchronous to the oscillator clock. They also assume that a request lasts at least one full clock period and is sampled only on rising edges. The stimulus meets these assumptions by changing every input on the falling edge, one clock at a time. Requests that arrive while a delay is running, and a select code that changes during a count, are applied on purpose, so the properties that claim these are ignored are actually exercised.

// File: rtl/su_pkg.sv
// Package: shared types for the start-up delay sequencer.
// Assumes: nothing beyond a 2-bit select code.
package su_pkg;
    typedef enum logic [1:0] {
        ST_COUNT = 2'd0,
        ST_READY = 2'd1,
        ST_SLEEP = 2'd2
    } su_state_e;

    localparam logic [1:0] SEL_NONE  = 2'b00;
    localparam logic [1:0] SEL_SHORT = 2'b01;
    localparam logic [1:0] SEL_LONG  = 2'b10;
    localparam logic [1:0] SEL_RSVD  = 2'b11;
endpackage

// File: rtl/su_sel_decode.sv
// su_sel_decode: turns the select code and the kind of delay into the
// terminal count (total cycles minus one). Purely combinational.
// Assumes: CNT_W holds RST_CYC + EXT_LONG - 1.
module su_sel_decode #(
    parameter int WAKE_CYC  = 6,
    parameter int RST_CYC   = 14,
    parameter int EXT_SHORT = 512,
    parameter int EXT_LONG  = 8192,
    parameter int CNT_W     = 14
) (
    input  logic [1:0]       sel,
    input  logic             is_wake,
    output logic [CNT_W-1:0] last_cnt,
    output logic             reserved
);
    import su_pkg::*;

    localparam logic [CNT_W-1:0] L_WAKE  = CNT_W'(WAKE_CYC - 1);
    localparam logic [CNT_W-1:0] L_NONE  = CNT_W'(RST_CYC - 1);
    localparam logic [CNT_W-1:0] L_SHORT = CNT_W'(RST_CYC + EXT_SHORT - 1);
    localparam logic [CNT_W-1:0] L_LONG  = CNT_W'(RST_CYC + EXT_LONG - 1);

    // Pick the terminal count for the delay about to start.
    always_comb begin
        reserved = (sel == SEL_RSVD);
        if (is_wake) begin
            last_cnt = L_WAKE;
        end else begin
            case (sel)
                SEL_NONE:  last_cnt = L_NONE;
                SEL_SHORT: last_cnt = L_SHORT;
                default:   last_cnt = L_LONG;
            endcase
        end
    end
endmodule

// File: rtl/su_cycle_counter.sv
// su_cycle_counter: counts oscillator cycles up from zero while run is high.
// It flags done on the cycle in which the count equals last, then holds.
// Assumes: last is stable while run is high; clear and run never overlap.
module su_cycle_counter #(
    parameter int CNT_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             run,
    input  logic [CNT_W-1:0] last,
    output logic             done
);
    logic [CNT_W-1:0] cnt_q;

    // Terminal-count detect.
    assign done = run && (cnt_q == last);

    // Count register: zero on reset or clear, advance until terminal.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else if (run && !done) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R4: counter never runs past the terminal value
    a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt_q <= last));
endmodule

// File: rtl/su_delay_seq.sv
// su_delay_seq: start-up delay sequencer. A reset or a wake request starts a
// delay; ready and clk_en rise when the delay ends and fall on a sleep request.
// Assumes: rst_n, sleep_req and wake_req are synchronous to clk_osc.
module su_delay_seq #(
    parameter int WAKE_CYC  = 6,
    parameter int RST_CYC   = 14,
    parameter int EXT_SHORT = 512,
    parameter int EXT_LONG  = 8192
) (
    input  logic       clk_osc,
    input  logic       rst_n,
    input  logic       sleep_req,
    input  logic       wake_req,
    input  logic [1:0] dly_sel,
    output logic       ready,
    output logic       clk_en,
    output logic       sel_err
);
    import su_pkg::*;

    localparam int CNT_W = $clog2(RST_CYC + EXT_LONG + 1);

    su_state_e        state_q;
    logic [CNT_W-1:0] last_q;
    logic [CNT_W-1:0] dec_last;
    logic             dec_rsvd;
    logic             err_q;
    logic             ready_q;
    logic             en_q;
    logic             cnt_done;
    logic             wake_go;
    logic             dec_wake;

    assign wake_go  = (state_q == ST_SLEEP) && wake_req;
    assign dec_wake = rst_n && (state_q == ST_SLEEP);

    su_sel_decode #(
        .WAKE_CYC (WAKE_CYC),
        .RST_CYC  (RST_CYC),
        .EXT_SHORT(EXT_SHORT),
        .EXT_LONG (EXT_LONG),
        .CNT_W    (CNT_W)
    ) u_dec (
        .sel     (dly_sel),
        .is_wake (dec_wake),
        .last_cnt(dec_last),
        .reserved(dec_rsvd)
    );

    su_cycle_counter #(
        .CNT_W(CNT_W)
    ) u_cnt (
        .clk  (clk_osc),
        .rst_n(rst_n),
        .clear(wake_go),
        .run  (state_q == ST_COUNT),
        .last (last_q),
        .done (cnt_done)
    );

    // Sequencer: capture the select code at delay start, then gate outputs.
    always_ff @(posedge clk_osc) begin
        if (!rst_n) begin
            state_q <= ST_COUNT;
            last_q  <= dec_last;
            err_q   <= dec_rsvd;
            ready_q <= 1'b0;
            en_q    <= 1'b0;
        end else begin
            case (state_q)
                ST_COUNT: begin
                    if (cnt_done) begin
                        state_q <= ST_READY;
                        ready_q <= 1'b1;
                        en_q    <= 1'b1;
                    end
                end
                ST_READY: begin
                    if (sleep_req) begin
                        state_q <= ST_SLEEP;
                        ready_q <= 1'b0;
                        en_q    <= 1'b0;
                    end
                end
                ST_SLEEP: begin
                    if (wake_req) begin
                        state_q <= ST_COUNT;
                        last_q  <= dec_last;
                        err_q   <= dec_rsvd;
                    end
                end
                default: state_q <= ST_COUNT;
            endcase
        end
    end

    assign ready   = ready_q;
    assign clk_en  = en_q;
    assign sel_err = err_q;

    // R7: ready holds unless a sleep request arrives
    a_r7_ready_hold: assert property (@(posedge clk_osc) disable iff (!rst_n)
        (ready && !sleep_req) |=> ready);

    // R6: a sleep request while ready drops ready and clk_en
    a_r6_sleep_drop: assert property (@(posedge clk_osc) disable iff (!rst_n)
        (ready && sleep_req) |=> (!ready && !clk_en));

    // R6: ready only rises when the counter reached its terminal value
    a_r6_rise_on_done: assert property (@(posedge clk_osc) disable iff (!rst_n)
        $rose(ready) |-> $past(cnt_done));

    // R8: captured delay and error flag stay fixed during a count
    a_r8_sel_held: assert property (@(posedge clk_osc) disable iff (!rst_n)
        ((state_q == ST_COUNT) && $past(state_q == ST_COUNT) && $past(rst_n))
            |-> ($stable(last_q) && $stable(sel_err)));

    // R9: wake request while ready does not leave the ready state
    a_r9_wake_ignored: assert property (@(posedge clk_osc) disable iff (!rst_n)
        (ready && wake_req && !sleep_req) |=> ready);
endmodule

// File: tb/tb_su_delay_seq.sv
module tb_su_delay_seq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sleep_req = 1'b0;
    logic       wake_req = 1'b0;
    logic [1:0] dly_sel = 2'b00;
    logic       ready;
    logic       clk_en;
    logic       sel_err;

    int    cyc = 0;
    int    total = 0;
    int    bad = 0;
    bit    finished = 1'b0;
    logic  ready_prev = 1'b0;
    int    q_cyc[$];
    bit    q_err[$];
    string q_tag[$];

    su_delay_seq dut (
        .clk_osc  (clk),
        .rst_n    (rst_n),
        .sleep_req(sleep_req),
        .wake_req (wake_req),
        .dly_sel  (dly_sel),
        .ready    (ready),
        .clk_en   (clk_en),
        .sel_err  (sel_err)
    );

    always #2 clk = ~clk;  // 250 MHz

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Monitor: on each rise of ready, pop the expected item and compare.
    always @(negedge clk) begin
        if (rst_n && ready && !ready_prev) begin
            if (q_cyc.size() == 0) begin
                chk(1'b0, "R9 unexpected ready rise", cyc, -1);
            end else begin
                int    ec;
                bit    ee;
                string et;
                ec = q_cyc.pop_front();
                ee = q_err.pop_front();
                et = q_tag.pop_front();
                chk(cyc == ec, {et, " ready edge"}, cyc, ec);
                chk(sel_err == ee, {et, " sel_err"}, int'(sel_err), int'(ee));
                chk(clk_en == 1'b1, "R7 clk_en with ready", int'(clk_en), 1);
            end
        end
        ready_prev <= ready;
    end

    // Driver: reset with a select code, push the expected rise edge.
    task automatic do_reset(input logic [1:0] s, input int n, input bit e, input string tag);
        @(negedge clk);
        dly_sel = s;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(!ready && !clk_en, "R1 outputs low in reset", int'(ready), 0);
        q_cyc.push_back(cyc + n);
        q_err.push_back(e);
        q_tag.push_back(tag);
        rst_n = 1'b1;
    endtask

    task automatic wait_drain();
        while (q_cyc.size() != 0) @(negedge clk);
    endtask

    task automatic go_sleep();
        @(negedge clk);
        sleep_req = 1'b1;
        @(negedge clk);
        sleep_req = 1'b0;
        chk(!ready && !clk_en, "R6 sleep drops ready", int'(ready), 0);
    endtask

    // Driver: one-cycle wake pulse, push expected rise edge.
    task automatic do_wake(input logic [1:0] s, input bit e, input string tag);
        @(negedge clk);
        dly_sel = s;
        wake_req = 1'b1;
        q_cyc.push_back(cyc + 1 + 6);
        q_err.push_back(e);
        q_tag.push_back(tag);
        @(negedge clk);
        wake_req = 1'b0;
    endtask

    initial begin
        // R2: code 00, 14 edges
        do_reset(2'b00, 14, 1'b0, "R2");
        wait_drain();
        repeat (20) @(negedge clk);
        chk(ready && clk_en, "R7 ready stays high", int'(ready), 1);

        // R3: code 01, select changed mid-count (R8)
        do_reset(2'b01, 526, 1'b0, "R3");
        @(negedge clk);
        dly_sel = 2'b11;  // R8: must not change length or sel_err
        wait_drain();

        // R4: code 10
        do_reset(2'b10, 8206, 1'b0, "R4");
        wait_drain();

        // R5: reserved code falls back to longest delay with error
        do_reset(2'b11, 8206, 1'b1, "R5");
        @(negedge clk);
        chk(sel_err == 1'b1, "R5 err during count", int'(sel_err), 1);
        dly_sel = 2'b00;
        wait_drain();

        // R6: sleep then wake; no wake means no ready
        go_sleep();
        repeat (5) @(negedge clk);
        chk(!ready, "R6 stays asleep without wake", int'(ready), 0);
        do_wake(2'b00, 1'b0, "R6 wake code 00");
        repeat (2) @(negedge clk);
        wake_req = 1'b1;   // R9: requests during a delay are ignored
        sleep_req = 1'b1;
        @(negedge clk);
        wake_req = 1'b0;
        sleep_req = 1'b0;
        wait_drain();

        // R6: wake delay is the same for other codes
        go_sleep();
        do_wake(2'b10, 1'b0, "R6 wake code 10");
        wait_drain();
        go_sleep();
        do_wake(2'b11, 1'b1, "R6 wake code 11");
        wait_drain();

        // R9: wake while ready has no effect
        @(negedge clk);
        wake_req = 1'b1;
        @(negedge clk);
        wake_req = 1'b0;
        repeat (3) @(negedge clk);
        chk(ready && clk_en, "R9 wake while ready ignored", int'(ready), 1);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    always @(negedge clk) begin
        if (!finished && cyc > 100000) begin
            finished = 1'b1;
            chk(1'b0, "watchdog", cyc, 100000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule